// File: doc/BRIEF.md
# UART Host Register Bank with Transmit Path

This block is the byte-wide register face of a classic 16550-style serial port. A host selects a register with a 4-bit word index and strobes a single-cycle write or read. Control registers for interrupt enables, FIFO control, line control, modem control, a scratch byte, the infrared-select byte and the 16-bit baud divisor live here. A banking bit in the line control register switches indices 0 and 1 over to the divisor bytes.

The block also owns the transmit side: a shift register, a one-byte holding register for non-FIFO operation and a parameterised transmit FIFO. It maintains the "transmitter empty" and "transmit data request" flags. A neighbouring serialiser reports the end of each character with a one-cycle pulse. Receive status, modem status, the interrupt identification byte and received data come from neighbouring blocks and are only multiplexed onto the read port here.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the interrupt-enable register reads 0x60, line control, modem control, FIFO control, scratch, infrared-select and divisor read 0. The transmitter is idle with the empty flag (LSR bit 6) and the data-request flag (LSR bit 5) both set.
- R2: Register indices are: 0 data, 1 interrupt enable, 2 interrupt identification on read and FIFO control on write, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 infrared select. A read returns its value on `rdata_o` one clock after the `rd_i` cycle. Line status reads as `lsr_i` with bits 6 and 5 replaced by the empty and data-request flags.
- R3: While line control bit 7 is set, index 0 and index 1 read and write the divisor low and high byte, and data and interrupt-enable accesses do not happen.
- R4: Bit 7 of the interrupt-enable register never changes on a write.
- R5: A data write while the transmitter is empty loads the shift register (`tx_byte_o`) and clears the empty flag (`tx_busy_o` high).
- R6: With FIFOs off, a data write while busy goes to the holding register and clears the data-request flag if that flag is set, and is dropped otherwise.
- R7: On `shift_done_i` while busy, the next byte is loaded from the FIFO (FIFO mode) or from the holding register (non-FIFO mode, setting the data-request flag). If no byte is available the empty flag is set.
- R8: In FIFO mode (FIFO control bit 0), a data write while busy is pushed unless the FIFO holds DEPTH bytes. The data-request flag clears when occupancy exceeds DEPTH/2 and sets when a pop leaves occupancy at or below DEPTH/2.
- R9: A FIFO control write that turns bit 0 on pulses `rx_flush_o` if bit 1 is set, and flushes the transmit FIFO and sets both flags if bit 2 is set. One that turns bit 0 off does all of these. One that leaves bit 0 unchanged flushes nothing.
- R10: An interrupt-enable write that takes bit 6 from 0 to 1 pulses `status_reset_o` in that cycle and sets both transmit flags.
- R11: A read of index 0 with line control bit 7 clear returns `rx_data_i` and pulses `rx_pop_o` in the `rd_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| idx_i | input | 4 | Register word index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| lsr_i | input | 8 | Receive-side line status bits |
| msr_i | input | 8 | Modem status byte |
| iir_i | input | 8 | Interrupt identification byte |
| rx_data_i | input | 8 | Head of receive data |
| rx_pop_o | output | 1 | Receive data consumed |
| rx_flush_o | output | 1 | Flush receive FIFO |
| status_reset_o | output | 1 | Reset receive and modem status |
| shift_done_i | input | 1 | Current character finished shifting |
| tx_busy_o | output | 1 | Shift register holds a character |
| tx_byte_o | output | 8 | Shift register contents |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| ir_sel_o | output | 8 | Infrared select register |
| divisor_o | output | 16 | Baud divisor |

## Verification
A wrong FIFO count or pointer shows up as a wrong `tx_byte_o` on the very next `shift_done_i`, or as the data-request bit flipping at a push count other than DEPTH/2+1. The bench runs a small depth so every occupancy level is crossed in both directions. Flag errors appear in the next line-status read, one clock after the read strobe. Banking or bit-7 lock faults show up as read-back mismatches in the scratch and divisor sweeps.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam logic [3:0] IDX_DATA = 4'd0;
  localparam logic [3:0] IDX_IER  = 4'd1;
  localparam logic [3:0] IDX_IIR  = 4'd2;
  localparam logic [3:0] IDX_LCR  = 4'd3;
  localparam logic [3:0] IDX_MCR  = 4'd4;
  localparam logic [3:0] IDX_LSR  = 4'd5;
  localparam logic [3:0] IDX_MSR  = 4'd6;
  localparam logic [3:0] IDX_SCR  = 4'd7;
  localparam logic [3:0] IDX_IRS  = 4'd8;
  localparam logic [7:0] IER_RST  = 8'h60;
  localparam int unsigned BIT_BANK = 7;
  localparam int unsigned BIT_UE   = 6;
  localparam int unsigned BIT_DMA  = 7;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [7:0]    din_i,
  output logic [7:0]    head_o,
  output logic [CW-1:0] cnt_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) if (push_i && !flush_i) mem_q[wp_q] <= din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_no_pop_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       wr_data_i,
  input  logic [7:0] din_i,
  input  logic       done_i,
  input  logic       fifo_flush_i,
  input  logic       flags_set_i,
  output logic       temt_o,
  output logic       tdrq_o,
  output logic [7:0] shift_o
);
  logic          temt_q, tdrq_q, temt_d, tdrq_d;
  logic [7:0]    shift_q, shift_d, hold_q, hold_d;
  logic          pop, push;
  logic [7:0]    head;
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_mid;

  uart_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(fifo_flush_i), .push_i(push), .pop_i(pop),
    .din_i, .head_o(head), .cnt_o(cnt)
  );

  always_comb begin
    temt_d = temt_q; tdrq_d = tdrq_q; shift_d = shift_q; hold_d = hold_q;
    pop = 1'b0; push = 1'b0;
    cnt_mid = {1'b0, cnt};
    // retire the finished character first, then accept the write
    if (done_i && !temt_q) begin
      if (fifo_en_i) begin
        if (cnt != '0) begin
          pop = 1'b1; shift_d = head; cnt_mid = {1'b0, cnt} - 1'b1;
          if (cnt_mid <= (CW+1)'(HALF)) tdrq_d = 1'b1;
        end else temt_d = 1'b1;
      end else if (tdrq_q) temt_d = 1'b1;
      else begin
        shift_d = hold_q; tdrq_d = 1'b1;
      end
    end
    if (wr_data_i) begin
      if (temt_d) begin
        shift_d = din_i; temt_d = 1'b0;
      end else if (fifo_en_i) begin
        if (cnt_mid < (CW+1)'(DEPTH)) begin
          push = 1'b1;
          if (cnt_mid + 1'b1 > (CW+1)'(HALF)) tdrq_d = 1'b0;
        end
      end else if (tdrq_d) begin
        hold_d = din_i; tdrq_d = 1'b0;
      end
    end
    if (flags_set_i) begin
      temt_d = 1'b1; tdrq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temt_q <= 1'b1; tdrq_q <= 1'b1; shift_q <= '0; hold_q <= '0;
    end else begin
      temt_q <= temt_d; tdrq_q <= tdrq_d; shift_q <= shift_d; hold_q <= hold_d;
    end
  end

  assign temt_o  = temt_q;
  assign tdrq_o  = tdrq_q;
  assign shift_o = shift_q;

  p_write_loads_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i && temt_q && !flags_set_i |=> !temt_q && shift_q == $past(din_i));
  p_holding_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !temt_q && !fifo_en_i && !tdrq_q && !wr_data_i && !flags_set_i
    |=> tdrq_q && !temt_q);
  p_flush_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_flush_i && flags_set_i |=> temt_q && tdrq_q && cnt == '0);
  p_over_half_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && push && !flags_set_i && cnt_mid >= (CW+1)'(HALF) |=> !tdrq_q);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [3:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [7:0]  lsr_i,
  input  logic [7:0]  msr_i,
  input  logic [7:0]  iir_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_pop_o,
  output logic        rx_flush_o,
  output logic        status_reset_o,
  input  logic        shift_done_i,
  output logic        tx_busy_o,
  output logic [7:0]  tx_byte_o,
  output logic [7:0]  ier_o,
  output logic [7:0]  fcr_o,
  output logic [7:0]  lcr_o,
  output logic [7:0]  mcr_o,
  output logic [7:0]  ir_sel_o,
  output logic [15:0] divisor_o
);
  logic [7:0] ier_q, fcr_q, lcr_q, mcr_q, scr_q, irs_q, dll_q, dlh_q, rdata_q;
  logic       bank, wr_data, ier_wr, fcr_wr, ue_rise, fifo_on, fifo_off, tx_flush;
  logic       temt, tdrq;
  logic [7:0] lsr_rd, rd_mux;

  assign bank     = lcr_q[BIT_BANK];
  assign wr_data  = wr_i && idx_i == IDX_DATA && !bank;
  assign ier_wr   = wr_i && idx_i == IDX_IER && !bank;
  assign fcr_wr   = wr_i && idx_i == IDX_IIR;
  assign ue_rise  = ier_wr && !ier_q[BIT_UE] && wdata_i[BIT_UE];
  assign fifo_on  = fcr_wr && !fcr_q[0] && wdata_i[0];
  assign fifo_off = fcr_wr && fcr_q[0] && !wdata_i[0];
  assign tx_flush = (fifo_on && wdata_i[2]) || fifo_off;

  assign rx_flush_o     = (fifo_on && wdata_i[1]) || fifo_off;
  assign status_reset_o = ue_rise;
  assign rx_pop_o       = rd_i && idx_i == IDX_DATA && !bank;

  uart_tx_path #(.DEPTH(TX_DEPTH)) u_tx (
    .clk_i, .rst_ni, .fifo_en_i(fcr_q[0]), .wr_data_i(wr_data), .din_i(wdata_i),
    .done_i(shift_done_i), .fifo_flush_i(tx_flush), .flags_set_i(tx_flush || ue_rise),
    .temt_o(temt), .tdrq_o(tdrq), .shift_o(tx_byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q <= IER_RST; fcr_q <= '0; lcr_q <= '0; mcr_q <= '0;
      scr_q <= '0; irs_q <= '0; dll_q <= '0; dlh_q <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        IDX_DATA: if (bank) dll_q <= wdata_i;
        IDX_IER:  if (bank) dlh_q <= wdata_i;
                  else ier_q <= {ier_q[BIT_DMA], wdata_i[6:0]};
        IDX_IIR:  fcr_q <= wdata_i;
        IDX_LCR:  lcr_q <= wdata_i;
        IDX_MCR:  mcr_q <= wdata_i;
        IDX_SCR:  scr_q <= wdata_i;
        IDX_IRS:  irs_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign lsr_rd = {lsr_i[7], temt, tdrq, lsr_i[4:0]};

  always_comb begin
    unique case (idx_i)
      IDX_DATA: rd_mux = bank ? dll_q : rx_data_i;
      IDX_IER:  rd_mux = bank ? dlh_q : ier_q;
      IDX_IIR:  rd_mux = iir_i;
      IDX_LCR:  rd_mux = lcr_q;
      IDX_MCR:  rd_mux = mcr_q;
      IDX_LSR:  rd_mux = lsr_rd;
      IDX_MSR:  rd_mux = msr_i;
      IDX_SCR:  rd_mux = scr_q;
      IDX_IRS:  rd_mux = irs_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign tx_busy_o = !temt;
  assign ier_o     = ier_q;
  assign fcr_o     = fcr_q;
  assign lcr_o     = lcr_q;
  assign mcr_o     = mcr_q;
  assign ir_sel_o  = irs_q;
  assign divisor_o = {dlh_q, dll_q};

  p_dma_bit_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr |=> ier_q[BIT_DMA] == $past(ier_q[BIT_DMA]));
  p_unit_enable_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_rise |=> !tx_busy_o);
  p_bank_blocks_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && idx_i == IDX_DATA && bank && !tx_busy_o && !shift_done_i |=> !tx_busy_o);
  p_read_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && idx_i == IDX_SCR && !(wr_i) |=> rdata_o == scr_q);
endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned HALF  = DEPTH / 2;
  localparam time TCK = 4ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, done = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  wdata = '0, lsr_in = 8'h81, msr_in = 8'h10, iir_in = 8'hC1, rxd = 8'h5A;
  logic [7:0]  rdata, tx_byte, ier, fcr, lcr, mcr, irs;
  logic [15:0] div;
  logic        rx_pop, rx_flush, st_rst, busy;
  int          n_cmp = 0, n_bad = 0;

  always #(TCK/2) clk = ~clk;

  uart_host_regs #(.TX_DEPTH(DEPTH)) i_uart_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .idx_i(idx), .wdata_i(wdata),
    .rdata_o(rdata), .lsr_i(lsr_in), .msr_i(msr_in), .iir_i(iir_in), .rx_data_i(rxd),
    .rx_pop_o(rx_pop), .rx_flush_o(rx_flush), .status_reset_o(st_rst),
    .shift_done_i(done), .tx_busy_o(busy), .tx_byte_o(tx_byte), .ier_o(ier),
    .fcr_o(fcr), .lcr_o(lcr), .mcr_o(mcr), .ir_sel_o(irs), .divisor_o(div)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; idx = i; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // write and report the combinational pulses seen in the strobe cycle
  task automatic wr_probe(input logic [3:0] i, input logic [7:0] d,
                          output logic fl, output logic sr);
    @(negedge clk); wr = 1'b1; idx = i; wdata = d;
    #1; fl = rx_flush; sr = st_rst;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] i, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; idx = i;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse_done;
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  function automatic int lsr_exp(input bit temt, input bit tdrq);
    return (lsr_in & 8'h9F) | (int'(temt) << 6) | (int'(tdrq) << 5);
  endfunction

  initial begin
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic fl, sr, pop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(4'd1, v); chk("R1 ier", v, 8'h60);
    rd_reg(4'd3, v); chk("R1 lcr", v, 0);
    rd_reg(4'd4, v); chk("R1 mcr", v, 0);
    rd_reg(4'd7, v); chk("R1 scr", v, 0);
    rd_reg(4'd8, v); chk("R1 irs", v, 0);
    chk("R1 fcr", fcr, 0); chk("R1 div", div, 0);
    rd_reg(4'd5, v); chk("R1 lsr", v, lsr_exp(1, 1));
    chk("R1 busy", busy, 0);

    // R2 index map and pass-through
    rd_reg(4'd2, v); chk("R2 iir", v, 8'hC1);
    rd_reg(4'd6, v); chk("R2 msr", v, 8'h10);
    for (int k = 0; k < 256; k += 7) begin
      wr_reg(4'd7, 8'(k)); rd_reg(4'd7, v); chk("R2 scr sweep", v, k);
      wr_reg(4'd8, 8'(k ^ 8'hFF)); rd_reg(4'd8, v); chk("R2 irs sweep", v, k ^ 8'hFF);
      wr_reg(4'd4, 8'(k + 3)); rd_reg(4'd4, v); chk("R2 mcr sweep", v, (k + 3) & 8'hFF);
    end

    // R3 divisor banking
    wr_reg(4'd3, 8'h83);
    wr_reg(4'd0, 8'h34); wr_reg(4'd1, 8'h12);
    chk("R3 no tx while banked", busy, 0);
    rd_reg(4'd0, v); chk("R3 dll", v, 8'h34);
    rd_reg(4'd1, v); chk("R3 dlh", v, 8'h12);
    chk("R3 divisor", div, 16'h1234);
    wr_reg(4'd3, 8'h03);
    rd_reg(4'd1, v); chk("R3 ier untouched", v, 8'h60);

    // R11 receive data read
    @(negedge clk); rd = 1'b1; idx = 4'd0; #1; pop = rx_pop;
    @(negedge clk); rd = 1'b0; v = rdata;
    chk("R11 pop", pop, 1); chk("R11 data", v, 8'h5A);

    // R4 DMA bit locked
    wr_reg(4'd1, 8'hFF); rd_reg(4'd1, v); chk("R4 set attempt", v, 8'h7F);

    // R5/R6/R7 non-FIFO transmit
    wr_reg(4'd0, 8'hA5);
    chk("R5 busy", busy, 1); chk("R5 shift", tx_byte, 8'hA5);
    rd_reg(4'd5, v); chk("R5 lsr", v, lsr_exp(0, 1));
    wr_reg(4'd0, 8'h3C);
    rd_reg(4'd5, v); chk("R6 holding full", v, lsr_exp(0, 0));
    wr_reg(4'd0, 8'h77);
    chk("R6 drop keeps shift", tx_byte, 8'hA5);
    pulse_done;
    chk("R7 reload holding", tx_byte, 8'h3C); chk("R7 busy", busy, 1);
    rd_reg(4'd5, v); chk("R7 tdrq set", v, lsr_exp(0, 1));
    pulse_done;
    chk("R7 idle", busy, 0); chk("R6 dropped byte absent", tx_byte, 8'h3C);

    // R10 unit enable rising
    wr_reg(4'd0, 8'h11); wr_reg(4'd0, 8'h22);
    wr_probe(4'd1, 8'h00, fl, sr); chk("R10 no pulse on clear", sr, 0);
    wr_probe(4'd1, 8'h40, fl, sr); chk("R10 pulse", sr, 1);
    rd_reg(4'd5, v); chk("R10 flags", v, lsr_exp(1, 1));
    wr_probe(4'd1, 8'h40, fl, sr); chk("R10 no pulse when held", sr, 0);

    // R9/R8 FIFO mode
    wr_probe(4'd2, 8'h07, fl, sr); chk("R9 rx flush on", fl, 1);
    rd_reg(4'd5, v); chk("R9 flags", v, lsr_exp(1, 1));
    wr_reg(4'd0, 8'h40);
    chk("R5 fifo first to shift", tx_byte, 8'h40);
    for (int k = 1; k <= DEPTH + 1; k++) begin
      wr_reg(4'd0, 8'(8'h40 + k));
      rd_reg(4'd5, v);
      chk("R8 tdrq on push", v, lsr_exp(0, (k <= HALF) ? 1 : 0));
    end
    for (int j = 1; j <= DEPTH; j++) begin
      pulse_done;
      chk("R8 pop order", tx_byte, 8'h40 + j);
      rd_reg(4'd5, v);
      chk("R8 tdrq on pop", v, lsr_exp(0, (DEPTH - j <= HALF) ? 1 : 0));
    end
    pulse_done;
    chk("R8 full push dropped", busy, 0);

    // R9 no toggle means no flush
    wr_reg(4'd0, 8'h90); wr_reg(4'd0, 8'h91); wr_reg(4'd0, 8'h92);
    wr_probe(4'd2, 8'h07, fl, sr); chk("R9 no toggle rx", fl, 0);
    pulse_done; chk("R9 fifo kept", tx_byte, 8'h91);
    // turning off flushes everything
    wr_reg(4'd0, 8'h93);
    wr_probe(4'd2, 8'h00, fl, sr); chk("R9 off rx flush", fl, 1);
    chk("R9 off idle", busy, 0);
    rd_reg(4'd5, v); chk("R9 off flags", v, lsr_exp(1, 1));
    // on with only tx reset bit clear: rx flush pulses, tx fifo contents survive flags
    wr_probe(4'd2, 8'h03, fl, sr); chk("R9 on rx only", fl, 1);
    wr_reg(4'd0, 8'hB0); wr_reg(4'd0, 8'hB1);
    wr_probe(4'd2, 8'h02, fl, sr); chk("R9 off again", fl, 1);
    chk("R9 off clears busy", busy, 0);
    wr_reg(4'd0, 8'hC0); pulse_done;
    chk("R9 flushed fifo empty", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule